// File: doc/BRIEF.md
# Quad-Channel Converter Command Port with Double Buffering

This block is the digital front end of a four-channel converter. A host sends command frames over a three-wire serial port: an active-low frame strobe, a bit clock and a data line. Each channel holds a staging register pair, made of a 16-bit code and a 4-bit span. Each channel also holds an active register pair that drives the converter. Commands write the staging code or the staging span, or copy staging to active for one channel or for all channels at once. A frame can be 24 bits long, or 32 bits long with eight leading filler bits. In a 32-bit frame the port returns staging contents on a serial output, so the host can verify them before it commits. A separate load pin copies staging to active on every channel in one step. This lets all four outputs move together without any serial traffic.

All serial inputs are sampled by the system clock `clk`, and edges on the bit clock are detected from those samples. The host must hold each bit-clock phase for at least two `clk` cycles. The port has no back-pressure: the host sets the pace, and the block accepts every bit it sees. A frame takes effect when the frame strobe rises. The active registers change two cycles later, together with a one-cycle strobe per channel. The load pin is passed through a two-stage synchroniser, and the copy follows its falling edge by three cycles.

Top module: `qdac_ifc`

## Requirements
- R1: After reset, every active code and span output is zero, `sdo` is low, and every staging code reads back as zero.
- R2: While `csn` is low, one bit is taken from `sdi` on each rising edge of `sck`. When `csn` rises, the last 24 bits are decoded in the order command[3:0], address[3:0], data[15:0], most significant bit first. A 32-bit frame decodes the same way; its first 8 bits are ignored.
- R3: Command 0011 loads the staging code with data[15:0]. The active outputs do not change.
- R4: Command 0010 loads the staging span with data[3:0]. The active outputs do not change.
- R5: Command 0100 copies the staging code and span into the active registers of the addressed channels. Its data bits are ignored.
- R6: Address 0000 selects channel 0, 0010 selects channel 1, 0100 selects channel 2 and 0110 selects channel 3. Address 1111 selects all four channels. Any other address changes nothing.
- R7: A frame whose bit count at the rising edge of `csn` is neither 24 nor 32 changes no register.
- R8: Bits 9 to 12 of a frame are its command field in the 32-bit layout. When they are 0010 and bits 13 to 16 select a single channel, `sdo` presents that channel's staging code, MSB first. The first bit appears after the 16th rising `sck` edge, and each later rising edge moves on one bit. At every other time `sdo` is low, including the whole time `csn` is high.
- R9: Command 1010 changes no register. If bits 9 to 12 of the frame hold 1010, the `sdo` window of R8 instead returns the addressed staging span, zero-extended to 16 bits.
- R10: A falling edge on `ldac_n` copies staging into active on all four channels.
- R11: `b2_upd[i]` pulses high for one cycle on every copy into channel i's active registers. The active outputs change only in that cycle.
- R12: Command values other than 0010, 0011, 0100 and 1010 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csn | input | 1 | Frame strobe, active low; the command executes when it rises |
| sck | input | 1 | Serial bit clock, sampled on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Load pin; its falling edge copies all channels |
| sdo | output | 1 | Serial readback out |
| b2_code | output | 64 | Active codes, channel i at bits [16i+15:16i] |
| b2_span | output | 16 | Active spans, channel i at bits [4i+3:4i] |
| b2_upd | output | 4 | One-cycle strobe for each channel's active update |

## Verification
The hardest case to reach is the readback window. It is decided at the 16th bit, before the frame length is known. A 24-bit frame whose upper data byte looks like a readback header therefore also drives `sdo`, and the bench model predicts this by the same bit-position rule. Random frames mix both layouts and random data bytes, so that aliasing case comes up repeatedly. The mix also covers staged writes read back before a commit, broadcast commits and load-pin pulses between frames. Odd frame lengths of 8, 23, 25, 31 and 33 bits are included to test the discard rule.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH      = 4;
  localparam int CODE_W   = 16;
  localparam int SPAN_W   = 4;
  localparam int CMD_W    = 4;
  localparam int ADDR_W   = 4;
  localparam int HDR_W    = CMD_W + ADDR_W;
  localparam int FRAME_W  = HDR_W + CODE_W;
  localparam int SHORT_LEN = FRAME_W;
  localparam int LONG_LEN  = FRAME_W + 8;
  localparam int HDR_POS   = LONG_LEN - FRAME_W + HDR_W;

  typedef enum logic [CMD_W-1:0] {
    OP_SPAN   = 4'b0010,
    OP_CODE   = 4'b0011,
    OP_UPD    = 4'b0100,
    OP_RDSPAN = 4'b1010
  } op_e;

  localparam logic [ADDR_W-1:0] ADDR_ALL = 4'hF;

  function automatic logic [NCH-1:0] addr_sel(input logic [ADDR_W-1:0] a);
    logic [NCH-1:0] s;
    s = '0;
    if (a == ADDR_ALL) s = '1;
    else
      for (int i = 0; i < NCH; i++)
        if (a == ADDR_W'(2 * i)) s[i] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/qdac_sport.sv
module qdac_sport
  import qdac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csn,
  input  logic               sck,
  input  logic               sdi,
  output logic               sck_rise,
  output logic               hdr_stb,
  output logic [HDR_W-1:0]   hdr,
  output logic               frm_stb,
  output logic [FRAME_W-1:0] frm
);
  localparam int CNT_W = $clog2(LONG_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LONG_LEN + 1);

  logic               csn_q, sck_q;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;

  assign sck_rise = sck & ~sck_q & ~csn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csn_q   <= 1'b1;
      sck_q   <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      hdr_stb <= 1'b0;
      hdr     <= '0;
      frm_stb <= 1'b0;
      frm     <= '0;
    end else begin
      csn_q   <= csn;
      sck_q   <= sck;
      hdr_stb <= 1'b0;
      frm_stb <= 1'b0;
      if (csn_q && !csn) begin
        cnt <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[FRAME_W-2:0], sdi};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(HDR_POS - 1)) begin
          hdr_stb <= 1'b1;
          hdr     <= {shreg[HDR_W-2:0], sdi};
        end
      end
      if (!csn_q && csn) begin
        frm_stb <= (cnt == CNT_W'(SHORT_LEN)) || (cnt == CNT_W'(LONG_LEN));
        frm     <= shreg;
      end
    end
  end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_code,
  input  logic              wr_span,
  input  logic              load,
  input  logic [CODE_W-1:0] data,
  output logic [CODE_W-1:0] b1_code,
  output logic [SPAN_W-1:0] b1_span,
  output logic [CODE_W-1:0] b2_code,
  output logic [SPAN_W-1:0] b2_span,
  output logic              upd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b1_code <= '0;
      b1_span <= '0;
      b2_code <= '0;
      b2_span <= '0;
      upd     <= 1'b0;
    end else begin
      upd <= load;
      if (wr_code) b1_code <= data;
      if (wr_span) b1_span <= data[SPAN_W-1:0];
      if (load) begin
        b2_code <= b1_code;
        b2_span <= b1_span;
      end
    end
  end
endmodule

// File: rtl/qdac_rdbk.sv
module qdac_rdbk
  import qdac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csn,
  input  logic                  sck_rise,
  input  logic                  hdr_stb,
  input  logic [HDR_W-1:0]      hdr,
  input  logic [NCH*CODE_W-1:0] b1c,
  input  logic [NCH*SPAN_W-1:0] b1s,
  output logic                  sdo
);
  logic [CODE_W-1:0] val, rb;
  logic [NCH-1:0]    sel;
  logic [CMD_W-1:0]  op;

  assign op  = hdr[HDR_W-1 -: CMD_W];
  assign sel = addr_sel(hdr[ADDR_W-1:0]);

  always_comb begin
    val = '0;
    for (int i = 0; i < NCH; i++)
      if (sel == (NCH'(1) << i)) begin
        if (op == OP_SPAN)        val = b1c[i*CODE_W +: CODE_W];
        else if (op == OP_RDSPAN) val = CODE_W'(b1s[i*SPAN_W +: SPAN_W]);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rb <= '0;
    else if (csn)      rb <= '0;
    else if (hdr_stb)  rb <= val;
    else if (sck_rise) rb <= {rb[CODE_W-2:0], 1'b0};
  end

  assign sdo = rb[CODE_W-1];
endmodule

// File: rtl/qdac_ifc.sv
module qdac_ifc
  import qdac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csn,
  input  logic                  sck,
  input  logic                  sdi,
  input  logic                  ldac_n,
  output logic                  sdo,
  output logic [NCH*CODE_W-1:0] b2_code,
  output logic [NCH*SPAN_W-1:0] b2_span,
  output logic [NCH-1:0]        b2_upd
);
  logic               sck_rise, hdr_stb, frm_stb;
  logic [HDR_W-1:0]   hdr;
  logic [FRAME_W-1:0] frm;
  logic [CMD_W-1:0]   op;
  logic [ADDR_W-1:0]  addr;
  logic [CODE_W-1:0]  data;
  logic [NCH-1:0]     sel;
  logic               l1, l2, l3, ldac_fall;
  logic [NCH*CODE_W-1:0] b1c;
  logic [NCH*SPAN_W-1:0] b1s;

  qdac_sport u_sport (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .sdi(sdi),
    .sck_rise(sck_rise), .hdr_stb(hdr_stb), .hdr(hdr),
    .frm_stb(frm_stb), .frm(frm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1 <= 1'b1; l2 <= 1'b1; l3 <= 1'b1;
    end else begin
      l1 <= ldac_n; l2 <= l1; l3 <= l2;
    end
  end
  assign ldac_fall = l3 & ~l2;

  assign op   = frm[FRAME_W-1 -: CMD_W];
  assign addr = frm[CODE_W +: ADDR_W];
  assign data = frm[CODE_W-1:0];
  assign sel  = addr_sel(addr);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qdac_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_code(frm_stb && (op == OP_CODE) && sel[g]),
      .wr_span(frm_stb && (op == OP_SPAN) && sel[g]),
      .load((frm_stb && (op == OP_UPD) && sel[g]) || ldac_fall),
      .data(data),
      .b1_code(b1c[g*CODE_W +: CODE_W]),
      .b1_span(b1s[g*SPAN_W +: SPAN_W]),
      .b2_code(b2_code[g*CODE_W +: CODE_W]),
      .b2_span(b2_span[g*SPAN_W +: SPAN_W]),
      .upd(b2_upd[g])
    );
  end

  qdac_rdbk u_rdbk (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sck_rise(sck_rise),
    .hdr_stb(hdr_stb), .hdr(hdr), .b1c(b1c), .b1s(b1s), .sdo(sdo)
  );
endmodule

// File: rtl/qdac_ifc_chk.sv
module qdac_ifc_chk
  import qdac_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  csn,
  input logic                  sdo,
  input logic [NCH*CODE_W-1:0] b2_code,
  input logic [NCH*SPAN_W-1:0] b2_span,
  input logic [NCH-1:0]        b2_upd,
  input logic [NCH*CODE_W-1:0] b1c,
  input logic                  frm_stb,
  input logic                  ldac_fall
);
  // R11: active registers move only alongside a strobe
  a_r11_change_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    ((b2_code != $past(b2_code)) || (b2_span != $past(b2_span))) |-> (b2_upd != '0));

  // R11: a strobe always follows a commit frame or a load-pin edge
  a_r11_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (b2_upd != '0) |-> ($past(frm_stb) || $past(ldac_fall)));

  // R8: serial output is idle while the strobe is high
  a_r8_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn)) |-> !sdo);

  // R3: staging codes are stable inside a frame
  a_r3_b1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && !$past(csn) && !$past(csn, 2)) |-> $stable(b1c));
endmodule

bind qdac_ifc qdac_ifc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn(csn), .sdo(sdo),
  .b2_code(b2_code), .b2_span(b2_span), .b2_upd(b2_upd),
  .b1c(b1c), .frm_stb(frm_stb), .ldac_fall(ldac_fall)
);

// File: tb/sim_qdac_ifc.sv
`timescale 1ns/1ps
module sim_qdac_ifc;
  logic clk = 1'b0, rst_n = 1'b0, csn = 1'b1, sck = 1'b0, sdi = 1'b0, ldac_n = 1'b1;
  logic sdo;
  logic [63:0] b2_code;
  logic [15:0] b2_span;
  logic [3:0]  b2_upd;

  qdac_ifc u0 (.clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .sdi(sdi),
               .ldac_n(ldac_n), .sdo(sdo), .b2_code(b2_code), .b2_span(b2_span),
               .b2_upd(b2_upd));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] m1c [4], m2c [4];
  logic [3:0]  m1s [4], m2s [4];
  int exp_upd [4], seen_upd [4];

  always @(negedge clk)
    if (rst_n) for (int i = 0; i < 4; i++) if (b2_upd[i]) seen_upd[i]++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] msel(input logic [3:0] a);
    case (a)
      4'h0: msel = 4'b0001;
      4'h2: msel = 4'b0010;
      4'h4: msel = 4'b0100;
      4'h6: msel = 4'b1000;
      4'hF: msel = 4'b1111;
      default: msel = 4'b0000;
    endcase
  endfunction

  function automatic int single(input logic [3:0] s);
    single = -1;
    for (int i = 0; i < 4; i++) if (s == (4'b1 << i)) single = i;
  endfunction

  function automatic logic [15:0] exp_rb(input logic [7:0] h);
    int c;
    c = single(msel(h[3:0]));
    exp_rb = 16'h0;
    if (c >= 0) begin
      if (h[7:4] == 4'b0010)      exp_rb = m1c[c];
      else if (h[7:4] == 4'b1010) exp_rb = {12'h0, m1s[c]};
    end
  endfunction

  task automatic model_copy(input logic [3:0] s);
    for (int i = 0; i < 4; i++)
      if (s[i]) begin m2c[i] = m1c[i]; m2s[i] = m1s[i]; exp_upd[i]++; end
  endtask

  task automatic check_outs(input string tag);
    logic [63:0] ec;
    logic [15:0] es;
    for (int i = 0; i < 4; i++) begin
      ec[i*16 +: 16] = m2c[i];
      es[i*4 +: 4]   = m2s[i];
    end
    chk(b2_code == ec, {tag, " code"}, b2_code, ec);
    chk(b2_span == es, {tag, " span"}, {48'h0, b2_span}, {48'h0, es});
  endtask

  task automatic send(input logic [31:0] w, input int n, input string tag);
    logic [15:0] rb;
    logic [7:0]  h;
    logic        e;
    logic [3:0]  op, s;
    h  = 8'(w >> (n - 16));
    rb = (n >= 16) ? exp_rb(h) : 16'h0;
    csn = 1'b0;
    tick(4);
    for (int k = 0; k < n; k++) begin
      sdi = w[n-1-k];
      tick(4);
      sck = 1'b1;
      tick(4);
      e = (k >= 15 && k <= 30) ? rb[30-k] : 1'b0;
      chk(sdo == e, {tag, " R8 sdo"}, {63'h0, sdo}, {63'h0, e});
      sck = 1'b0;
    end
    tick(4);
    csn = 1'b1;
    tick(6);
    chk(sdo == 1'b0, "R8 idle", {63'h0, sdo}, 64'h0);
    if (n == 24 || n == 32) begin
      op = w[23:20];
      s  = msel(w[19:16]);
      for (int i = 0; i < 4; i++)
        if (s[i]) begin
          if (op == 4'b0011) m1c[i] = w[15:0];
          if (op == 4'b0010) m1s[i] = w[3:0];
        end
      if (op == 4'b0100) model_copy(s);
    end
    check_outs(tag);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0;
    tick(4);
    ldac_n = 1'b1;
    model_copy(4'b1111);
    tick(6);
    check_outs("R10 load pin");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int dummy;
    logic [31:0] w;
    int n, r;
    logic [3:0] op, ad;
    dummy = $urandom(32'd4711);
    for (int i = 0; i < 4; i++) begin
      m1c[i] = 0; m2c[i] = 0; m1s[i] = 0; m2s[i] = 0; exp_upd[i] = 0; seen_upd[i] = 0;
    end
    tick(5);
    rst_n = 1'b1;
    tick(3);
    check_outs("R1 reset");
    chk(sdo == 1'b0, "R1 sdo", {63'h0, sdo}, 64'h0);
    for (int c = 0; c < 4; c++)
      send({8'h00, 4'b0010, 4'(2*c), 16'h0000}, 32, "R1 code reads zero");

    // 24-bit sequence: spans all, span ch0, code all, code ch0, commit all
    send({8'h0, 24'h2F0003}, 24, "R4 span all");
    send({8'h0, 24'h200001}, 24, "R4 span ch0");
    send({8'h0, 24'h3F8000}, 24, "R3 code all");
    send({8'h0, 24'h300000}, 24, "R3 code ch0");
    chk(b2_code == 64'h0, "R3 no output change", b2_code, 64'h0);
    send({8'h0, 24'h4FABCD}, 24, "R5 commit all");
    chk(b2_code == 64'h8000_8000_8000_0000, "R6 broadcast code", b2_code, 64'h8000_8000_8000_0000);
    chk(b2_span == 16'h3331, "R6 broadcast span", {48'h0, b2_span}, 64'h3331);

    // 32-bit sequence on channel 2 with readback
    send(32'h0034_8000, 32, "R3 code ch2");
    send(32'h0024_0004, 32, "R8 span write with code readback");
    send(32'h00A4_FFFF, 32, "R9 span readback");
    send(32'h0044_0000, 32, "R5 commit ch2");
    chk(b2_span[11:8] == 4'h4, "R5 ch2 span", {60'h0, b2_span[11:8]}, 64'h4);

    // discarded lengths, unknown address and command
    send(32'h0030_1234, 23, "R7 short frame");
    send(32'h0030_1234, 33, "R7 long frame");
    send(32'h0031_5555, 32, "R6 odd address");
    send(32'h0070_5555, 32, "R12 unknown cmd");
    send(32'h000F_0000, 32, "R2 prefix ignored");
    send(32'hFF4F_0000, 32, "R2 prefix bits ignored");
    pulse_ldac();

    for (int t = 0; t < 300; t++) begin
      r = $urandom % 6;
      case (r)
        0: op = 4'b0010; 1, 5: op = 4'b0011; 2: op = 4'b0100; 3: op = 4'b1010;
        default: op = 4'($urandom);
      endcase
      r = $urandom % 6;
      ad = (r == 5) ? 4'($urandom) : ((r == 4) ? 4'hF : 4'(2 * r));
      w = {8'($urandom), op, ad, 16'($urandom)};
      r = $urandom % 10;
      if (r < 5) n = 32;
      else if (r < 9) begin n = 24; w = {8'h0, 8'($urandom), 16'($urandom)}; if (r < 7) w[23:16] = {op, ad}; end
      else begin r = $urandom % 5; n = (r == 0) ? 8 : (r == 1) ? 23 : (r == 2) ? 25 : (r == 3) ? 31 : 33; end
      send(w, n, "R2 random frame");
      if ($urandom % 15 == 0) pulse_ldac();
    end

    tick(4);
    for (int i = 0; i < 4; i++)
      chk(seen_upd[i] == exp_upd[i], "R11 strobe count", 64'(seen_upd[i]), 64'(exp_upd[i]));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule